// File: doc/BRIEF.md
# UART Transmit-Empty Interrupt Generator

This block decides when a FIFO-mode UART tells its interrupt logic that the transmit side is empty, and it holds the resulting interrupt request. It watches how full the transmit FIFO is, the CPU's writes to the holding register and reads of the interrupt identification register, a tick at the end of each last stop bit, and the per-bit baud tick. From these it produces a registered empty flag and an interrupt request.

The empty flag is not always raised as soon as the FIFO count reaches zero. If the FIFO has held only one byte at a time since the last empty event, the flag is held back. The delay starts at the next end-of-stop-bit tick and then lasts one character time minus the stop bit, counted in baud ticks. If the FIFO held two or more bytes at some point, the flag rises at once. The first empty event after the FIFO-enable bit changes also rises at once, and so does any empty event while FIFO mode is off.

The interrupt is latched on each rising edge of the empty flag. A holding-register write or an identification read clears it. The request is shown at the output only while both FIFO mode and the transmit interrupt are enabled. Every pin is a plain control or status level or a one-cycle pulse. No data passes through the block, so it has no valid/ready handshake and no back-pressure.

Top module: `uart_thre_irq`

## Requirements
- R1: After reset the empty flag `thre` is 1 and `irq` is 0.
- R2: In the clock cycle after `tx_count` is nonzero, `thre` is 0.
- R3: If `tx_count` was 2 or more at any time since the last rise of `thre`, then `thre` rises in the cycle after `tx_count` is first seen at 0.
- R4: Otherwise, in FIFO mode the block ignores baud ticks until the first `stop_end` pulse after the count reaches 0. It then counts baud ticks, and `thre` rises on the tick numbered 6 + `char_len`. The `char_len` encoding is 0 to 3 for 5 to 8 data bits.
- R5: The first empty event after any change of `fifo_en` raises `thre` in the next cycle, with no delay.
- R6: While `fifo_en` is 0, `thre` rises in the cycle after the count is seen at 0.
- R7: A `thr_wr` pulse while a delayed rise is pending cancels it. The next rise then again waits for a fresh `stop_end` pulse and the full tick count.
- R8: Each rise of `thre` sets a pending latch. `irq` equals that latch ANDed with `fifo_en` and `txint_en`, so a latch set while the interrupt is disabled shows once it is enabled.
- R9: A `thr_wr` pulse clears the pending latch in the next cycle.
- R10: An `iir_rd` pulse clears the pending latch in the next cycle. When a rise of `thre` and a clear pulse happen in the same cycle, the latch is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fifo_en | input | 1 | FIFO mode enable |
| txint_en | input | 1 | Transmit interrupt enable |
| char_len | input | 2 | Data bits minus 5 |
| tx_count | input | 5 | Transmit FIFO occupancy |
| thr_wr | input | 1 | Pulse: CPU write to the holding register |
| iir_rd | input | 1 | Pulse: CPU read of the identification register |
| stop_end | input | 1 | Pulse: end of the last stop bit |
| baud_tick | input | 1 | Pulse: one bit time |
| thre | output | 1 | Empty flag as seen by the interrupt logic |
| irq | output | 1 | Transmit-empty interrupt request |

## Verification
The hardest situation to reach is a delayed rise that is cancelled part way through its tick count and then restarted. The stimulus must keep the FIFO at single-byte occupancy and wait for a stop-bit tick. It must then supply only some of the baud ticks and write in that window. Directed steps build this sequence with exact tick counts. Random episodes then hold each FIFO count for several cycles, mostly 0 or 1, with sparse stop-bit, write and read pulses and rare enable and length changes. This lets long single-byte delays complete, get cut short, and overlap with clears.

// File: rtl/uart_thre_pkg.sv
package uart_thre_pkg;
  localparam int unsigned DATA_MIN = 5;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_WAIT  = 2'd1,
    PH_COUNT = 2'd2
  } dly_phase_t;
endpackage

// File: rtl/thre_qualify.sv
module thre_qualify #(
  parameter int unsigned CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fifo_en,
  input  logic [CNT_W-1:0] tx_count,
  input  logic             raise,
  output logic             qualify
);
  localparam logic [CNT_W-1:0] TWO = CNT_W'(2);

  logic saw_two_q, first_q, fen_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      saw_two_q <= 1'b0;
      first_q   <= 1'b1;
      fen_q     <= 1'b0;
    end else begin
      saw_two_q <= (tx_count >= TWO) | (saw_two_q & ~raise);
      if (fifo_en != fen_q)
        first_q <= 1'b1;
      else if (raise)
        first_q <= 1'b0;
      fen_q <= fifo_en;
    end
  end

  assign qualify = ~fifo_en | saw_two_q | first_q;

  // R3
  saw_two_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_count >= TWO) |=> saw_two_q);
  // R5
  en_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_en != fen_q) |=> first_q);
endmodule

// File: rtl/thre_delay.sv
module thre_delay
  import uart_thre_pkg::*;
#(
  parameter int unsigned CNT_W = 5,
  parameter int unsigned LEN_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] tx_count,
  input  logic [LEN_W-1:0] char_len,
  input  logic             qualify,
  input  logic             thr_wr,
  input  logic             stop_end,
  input  logic             baud_tick,
  output logic             thre,
  output logic             raise
);
  localparam int unsigned MAX_DLY = 1 + DATA_MIN + (2**LEN_W) - 1;
  localparam int unsigned TMR_W   = $clog2(MAX_DLY + 1);

  dly_phase_t       ph_q, ph_d;
  logic [TMR_W-1:0] cnt_q, cnt_d, load_v;
  logic             thre_q, thre_d;

  assign load_v = TMR_W'(DATA_MIN) + TMR_W'(char_len);

  always_comb begin
    ph_d   = ph_q;
    cnt_d  = cnt_q;
    thre_d = thre_q;
    raise  = 1'b0;
    if (tx_count != '0) begin
      thre_d = 1'b0;
      ph_d   = PH_IDLE;
    end else if (!thre_q) begin
      if (qualify) begin
        thre_d = 1'b1;
        raise  = 1'b1;
        ph_d   = PH_IDLE;
      end else if (thr_wr) begin
        ph_d = PH_IDLE;
      end else begin
        case (ph_q)
          PH_IDLE: ph_d = PH_WAIT;
          PH_WAIT: begin
            if (stop_end) begin
              ph_d  = PH_COUNT;
              cnt_d = load_v;
            end
          end
          PH_COUNT: begin
            if (baud_tick) begin
              if (cnt_q == '0) begin
                thre_d = 1'b1;
                raise  = 1'b1;
                ph_d   = PH_IDLE;
              end else begin
                cnt_d = cnt_q - 1'b1;
              end
            end
          end
          default: ph_d = PH_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      cnt_q  <= '0;
      thre_q <= 1'b1;
    end else begin
      ph_q   <= ph_d;
      cnt_q  <= cnt_d;
      thre_q <= thre_d;
    end
  end

  assign thre = thre_q;

  // R2
  nonempty_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_count != '0) |=> !thre_q);
  // R4
  tick_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_COUNT && baud_tick && cnt_q != '0 && tx_count == '0 &&
     !thre_q && !qualify && !thr_wr) |=> (cnt_q == $past(cnt_q) - 1'b1));
  // R7
  wr_cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_count == '0 && !thre_q && !qualify && thr_wr) |=> (ph_q == PH_IDLE && !thre_q));
endmodule

// File: rtl/thre_irq.sv
module thre_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic raise,
  input  logic thr_wr,
  input  logic iir_rd,
  input  logic fifo_en,
  input  logic txint_en,
  output logic irq
);
  logic pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= raise | (pend_q & ~(thr_wr | iir_rd));
  end

  assign irq = pend_q & fifo_en & txint_en;

  // R8
  pend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    raise |=> pend_q);
  // R9
  wr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!raise && thr_wr) |=> !pend_q);
  // R10
  rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!raise && iir_rd) |=> !pend_q);
endmodule

// File: rtl/uart_thre_irq.sv
module uart_thre_irq #(
  parameter int unsigned FIFO_DEPTH = 16,
  parameter int unsigned LEN_W      = 2,
  localparam int unsigned CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fifo_en,
  input  logic             txint_en,
  input  logic [LEN_W-1:0] char_len,
  input  logic [CNT_W-1:0] tx_count,
  input  logic             thr_wr,
  input  logic             iir_rd,
  input  logic             stop_end,
  input  logic             baud_tick,
  output logic             thre,
  output logic             irq
);
  logic qualify, raise;

  thre_qualify #(.CNT_W(CNT_W)) u_qual (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .tx_count(tx_count),
    .raise(raise), .qualify(qualify)
  );

  thre_delay #(.CNT_W(CNT_W), .LEN_W(LEN_W)) u_dly (
    .clk(clk), .rst_n(rst_n), .tx_count(tx_count), .char_len(char_len),
    .qualify(qualify), .thr_wr(thr_wr), .stop_end(stop_end),
    .baud_tick(baud_tick), .thre(thre), .raise(raise)
  );

  thre_irq u_irq (
    .clk(clk), .rst_n(rst_n), .raise(raise), .thr_wr(thr_wr),
    .iir_rd(iir_rd), .fifo_en(fifo_en), .txint_en(txint_en), .irq(irq)
  );

  // R3
  fast_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_count == '0 && !thre && qualify) |=> thre);
endmodule

// File: tb/test_uart_thre_irq.sv
module test_uart_thre_irq;
  localparam int CW = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic fifo_en = 0, txint_en = 0, thr_wr = 0, iir_rd = 0, stop_end = 0, baud_tick = 0;
  logic [1:0] char_len = 0;
  logic [CW-1:0] tx_count = 0;
  logic thre, irq;

  int checks = 0, errors = 0;
  string cur_req = "R1";
  bit done = 0;

  always #4 clk = ~clk;

  uart_thre_irq i_uart_thre_irq (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .txint_en(txint_en),
    .char_len(char_len), .tx_count(tx_count), .thr_wr(thr_wr), .iir_rd(iir_rd),
    .stop_end(stop_end), .baud_tick(baud_tick), .thre(thre), .irq(irq)
  );

  // reference model built from the requirements
  bit m_thre = 1, m_pend = 0, m_saw = 0, m_first = 1, m_fen = 0;
  int m_ph = 0, m_cnt = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_thre = 1; m_pend = 0; m_saw = 0; m_first = 1; m_fen = 0; m_ph = 0; m_cnt = 0;
    end else begin
      bit rz, q;
      rz = 0;
      q  = !fifo_en || m_saw || m_first;
      if (tx_count != 0) begin
        m_thre = 0; m_ph = 0;
      end else if (!m_thre) begin
        if (q) begin m_thre = 1; rz = 1; m_ph = 0; end
        else if (thr_wr) m_ph = 0;
        else if (m_ph == 0) m_ph = 1;
        else if (m_ph == 1) begin
          if (stop_end) begin m_ph = 2; m_cnt = 5 + int'(char_len); end
        end else if (baud_tick) begin
          if (m_cnt == 0) begin m_thre = 1; rz = 1; m_ph = 0; end
          else m_cnt = m_cnt - 1;
        end
      end
      m_saw = (tx_count >= 2) || (m_saw && !rz);
      if (fifo_en != m_fen) m_first = 1;
      else if (rz) m_first = 0;
      m_fen = fifo_en;
      m_pend = rz || (m_pend && !(thr_wr || iir_rd));
    end
  end

  function automatic bit exp_irq();
    return m_pend && fifo_en && txint_en;
  endfunction

  task automatic chk(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b t=%0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(cur_req, thre, m_thre);
      chk(cur_req, irq, exp_irq());
    end
  end

  task automatic cyc();
    @(posedge clk); #1;
    thr_wr = 0; iir_rd = 0; stop_end = 0; baud_tick = 0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'h1a2b3c4d));
    repeat (5) @(posedge clk);
    #1 rst_n = 1;
    // R1 reset state
    chk("R1", thre, 1'b1); chk("R1", irq, 1'b0);

    cur_req = "R2";
    fifo_en = 1; txint_en = 1; cyc();
    tx_count = 1; cyc();
    chk("R2", thre, 1'b0);
    tx_count = 0; cyc();
    chk("R5", thre, 1'b1); chk("R8", irq, 1'b1);

    cur_req = "R10";
    iir_rd = 1; cyc();
    chk("R10", irq, 1'b0);

    // R4 single-byte delay, char_len 0 -> 6 ticks after stop_end
    cur_req = "R4";
    tx_count = 1; cyc();
    tx_count = 0; cyc();
    chk("R4", thre, 1'b0);
    repeat (3) begin baud_tick = 1; cyc(); end
    chk("R4", thre, 1'b0);
    stop_end = 1; cyc();
    repeat (5) begin baud_tick = 1; cyc(); end
    chk("R4", thre, 1'b0);
    baud_tick = 1; cyc();
    chk("R4", thre, 1'b1); chk("R8", irq, 1'b1);
    cur_req = "R9";
    thr_wr = 1; cyc();
    chk("R9", irq, 1'b0);

    // R3 two bytes held: immediate
    cur_req = "R3";
    tx_count = 1; cyc(); tx_count = 2; cyc(); tx_count = 1; cyc();
    tx_count = 0; cyc();
    chk("R3", thre, 1'b1);
    thr_wr = 1; cyc();

    // R7 cancel while counting
    cur_req = "R7";
    char_len = 3;
    tx_count = 1; cyc(); tx_count = 0; cyc(); cyc();
    stop_end = 1; cyc();
    repeat (2) begin baud_tick = 1; cyc(); end
    thr_wr = 1; cyc();
    repeat (12) begin baud_tick = 1; cyc(); end
    chk("R7", thre, 1'b0);
    stop_end = 1; cyc();
    repeat (8) begin baud_tick = 1; cyc(); end
    chk("R7", thre, 1'b0);
    baud_tick = 1; cyc();
    chk("R4", thre, 1'b1);
    iir_rd = 1; cyc();

    // R6 FIFO mode off: immediate, twice
    cur_req = "R6";
    fifo_en = 0; tx_count = 1; cyc(); tx_count = 0; cyc();
    chk("R6", thre, 1'b1); chk("R8", irq, 1'b0);
    tx_count = 1; cyc(); tx_count = 0; cyc();
    chk("R6", thre, 1'b1);
    cur_req = "R8";
    fifo_en = 1; cyc();
    chk("R8", irq, 1'b1);
    iir_rd = 1; cyc();
    chk("R10", irq, 1'b0);

    // R5 after enable change, with same-cycle read (R10 set wins)
    cur_req = "R5";
    tx_count = 1; cyc();
    tx_count = 0; iir_rd = 1; cyc();
    chk("R5", thre, 1'b1); chk("R10", irq, 1'b1);
    thr_wr = 1; cyc();

    // random episodes
    cur_req = "R4";
    for (int e = 0; e < 2500; e++) begin
      int r, len;
      r = $urandom_range(0, 99);
      tx_count = (r < 50) ? 0 : (r < 80) ? 1 : CW'($urandom_range(2, 16));
      len = $urandom_range(1, 30);
      for (int c = 0; c < len; c++) begin
        baud_tick = ($urandom_range(0, 2) == 0);
        stop_end  = ($urandom_range(0, 19) == 0);
        thr_wr    = ($urandom_range(0, 29) == 0);
        iir_rd    = ($urandom_range(0, 29) == 0);
        if ($urandom_range(0, 399) == 0) fifo_en = ~fifo_en;
        if ($urandom_range(0, 99) == 0) txint_en = ~txint_en;
        if ($urandom_range(0, 199) == 0) char_len = 2'($urandom_range(0, 3));
        cyc();
      end
    end
    @(negedge clk);
    finish_run();
  end
endmodule